// File: doc/BRIEF.md
# Codec Command Slot Channel

This block is the control side of a serial codec link. The host loads two 20-bit slot words. The command slot carries a direction flag and a 7-bit codec register address. The data slot carries 16 bits of write data. Loading the command slot starts the command. A write command stores the data slot value in a model of the codec's register bank. A read command fetches a bank entry and returns it, together with an echo of the command slot, through two receive slot registers.

A flag vector is always visible at the ports, so the host can poll it. It shows which transmit slots are still empty, whether a read is in flight, and whether fresh receive data is waiting. Reading a receive slot through the read port consumes its valid flag. The register bank model resets to zero and keeps one entry per even address. Line framing, bit timing and the audio sample slots belong to other blocks.

Top module: `codec_cmd_slot`

## Requirements
- R1: After reset `slotFlags` equals 0x07. Its bits are: 0 command-slot empty, 1 data-slot empty, 2 both-slots empty, 3 command receive busy, 4 data receive busy, 5 command receive valid, 6 data receive valid. Both receive slot registers read 0.
- R2: Writing the command slot (`wrSel`=0) clears bits 0 and 2 on the next edge. Writing the data slot (`wrSel`=1) clears bits 1 and 2 and leaves bit 0 alone. No empty flag is set again without a reset.
- R3: A command word with bit 19 = 0 is a write. One cycle after the command slot is loaded, bits 19:4 of the data slot are stored at the address in command bits 18:12. Address bit 0 is ignored, so addresses 2k and 2k+1 are the same entry.
- R4: A command word with bit 19 = 1 is a read. One cycle after the command slot is loaded, the command receive slot (`rdSel`=2) holds the command word with bit 19 cleared. The data receive slot (`rdSel`=3) holds the addressed 16-bit value shifted left by 4, with bits 3:0 zero.
- R5: Loading a read command sets both receive busy flags on the next edge. On the edge after that, the flags are cleared and both receive valid flags are set.
- R6: A read strobe (`rdEn`) on `rdSel`=2 clears bit 5, and on `rdSel`=3 clears bit 6. A read strobe on a transmit slot changes no flag.
- R7: A write command changes neither receive slot register nor any receive valid flag.
- R8: Every register bank entry reads 0 after reset.
- R9: If a read completes in the same cycle that a receive slot is read, the valid flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Slot write strobe |
| wrSel | input | 2 | Written slot: 0 command, 1 data |
| wrData | input | 20 | Slot word to write |
| rdEn | input | 1 | Read strobe; consumes the valid flag of a receive slot |
| rdSel | input | 2 | Read slot: 0 command tx, 1 data tx, 2 command rx, 3 data rx |
| rdData | output | 20 | Selected slot word (combinational) |
| slotFlags | output | 7 | Slot flag vector, bits as in R1 |

## Verification
The hardest case to reach is the collision between a read completing and the host consuming the receive slot in the same cycle (R9). The bench gets there by asserting the receive-slot read strobe on the cycle right after a read command is loaded, which is the cycle in which the command executes. Address aliasing (R3) is reached by writing an odd address and reading back through its even partner, and the reverse. An entry that was never written is read to confirm the reset value (R8).

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;

  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_DAT    = 2'd1,
    SEL_RX_CMD = 2'd2,
    SEL_RX_DAT = 2'd3
  } slotSel_e;

  // packed MSB first: cmdEmpty lands on bit 0
  typedef struct packed {
    logic rx2Valid;
    logic rx1Valid;
    logic rx2Busy;
    logic rx1Busy;
    logic bothEmpty;
    logic datEmpty;
    logic cmdEmpty;
  } slotFlags_t;

  typedef struct packed {
    logic loadCmd;
    logic loadDat;
    logic execWrite;
    logic execRead;
  } slotStrb_t;

  localparam slotFlags_t FLAGS_RESET = '{rx2Valid: 1'b0, rx1Valid: 1'b0,
                                         rx2Busy: 1'b0, rx1Busy: 1'b0,
                                         bothEmpty: 1'b1, datEmpty: 1'b1,
                                         cmdEmpty: 1'b1};

endpackage

// File: rtl/codec_slot_ctrl.sv
module codec_slot_ctrl
  import codec_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  slotSel_e   wrSel,
  input  logic       rdFlagIn,
  input  logic       rdEn,
  input  slotSel_e   rdSel,
  output slotStrb_t  strb,
  output slotFlags_t flags
);

  logic       pendValid;
  logic       pendRead;
  slotFlags_t flagsNext;

  always_comb begin
    strb.loadCmd   = wrEn && (wrSel == SEL_CMD);
    strb.loadDat   = wrEn && (wrSel == SEL_DAT);
    strb.execWrite = pendValid && !pendRead;
    strb.execRead  = pendValid && pendRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendRead  <= 1'b0;
    end else begin
      pendValid <= strb.loadCmd;
      if (strb.loadCmd) pendRead <= rdFlagIn;
    end
  end

  // order matters: consume, then completion, then new load
  always_comb begin
    flagsNext = flags;
    if (rdEn && rdSel == SEL_RX_CMD) flagsNext.rx1Valid = 1'b0;
    if (rdEn && rdSel == SEL_RX_DAT) flagsNext.rx2Valid = 1'b0;
    if (strb.execRead) begin
      flagsNext.rx1Busy  = 1'b0;
      flagsNext.rx2Busy  = 1'b0;
      flagsNext.rx1Valid = 1'b1;
      flagsNext.rx2Valid = 1'b1;
    end
    if (strb.loadCmd) begin
      flagsNext.cmdEmpty  = 1'b0;
      flagsNext.bothEmpty = 1'b0;
      if (rdFlagIn) begin
        flagsNext.rx1Busy = 1'b1;
        flagsNext.rx2Busy = 1'b1;
      end
    end
    if (strb.loadDat) begin
      flagsNext.datEmpty  = 1'b0;
      flagsNext.bothEmpty = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= FLAGS_RESET;
    else       flags <= flagsNext;
  end

  // R2
  cmd_empty_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCmd |=> !flags.cmdEmpty && !flags.bothEmpty);
  // R2
  dat_empty_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDat |=> !flags.datEmpty && !flags.bothEmpty);
  // R2
  empty_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(flags.cmdEmpty) && !$rose(flags.datEmpty));
  // R5
  busy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadCmd && rdFlagIn) |=> flags.rx1Busy && flags.rx2Busy);
  // R5
  read_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.execRead |=> flags.rx1Valid && flags.rx2Valid);
  // R6
  valid_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == SEL_RX_CMD && !strb.execRead) |=> !flags.rx1Valid);

endmodule

// File: rtl/codec_slot_dp.sv
module codec_slot_dp
  import codec_slot_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrb_t         strb,
  input  logic [SLOT_W-1:0] wrData,
  input  slotSel_e          rdSel,
  output logic [SLOT_W-1:0] rdData
);

  localparam int ADDR_HI = SLOT_W - 2;
  localparam int ADDR_LO = ADDR_HI - ADDR_W + 1;
  localparam int DAT_LO  = SLOT_W - DATA_W;
  localparam int IDX_W   = ADDR_W - 1;
  localparam int DEPTH   = 2 ** IDX_W;

  logic [SLOT_W-1:0] txCmd, txDat, rxCmd, rxDat;
  logic [DATA_W-1:0] bank [DEPTH];
  logic [IDX_W-1:0]  bankIdx;

  assign bankIdx = txCmd[ADDR_HI:ADDR_LO+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCmd <= '0;
      txDat <= '0;
    end else begin
      if (strb.loadCmd) txCmd <= wrData;
      if (strb.loadDat) txDat <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else if (strb.execWrite) begin
      bank[bankIdx] <= txDat[SLOT_W-1:DAT_LO];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCmd <= '0;
      rxDat <= '0;
    end else if (strb.execRead) begin
      rxCmd <= {1'b0, txCmd[SLOT_W-2:0]};
      rxDat <= {bank[bankIdx], {DAT_LO{1'b0}}};
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_CMD:    rdData = txCmd;
      SEL_DAT:    rdData = txDat;
      SEL_RX_CMD: rdData = rxCmd;
      default:    rdData = rxDat;
    endcase
  end

  // R4
  rx_cmd_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.execRead |=> !rxCmd[SLOT_W-1] && rxCmd[SLOT_W-2:0] == $past(txCmd[SLOT_W-2:0]));
  // R4
  rx_dat_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.execRead |=> rxDat[DAT_LO-1:0] == '0);
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.execRead |=> $stable(rxCmd) && $stable(rxDat));

endmodule

// File: rtl/codec_cmd_slot.sv
module codec_cmd_slot
  import codec_slot_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [SLOT_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [1:0]        rdSel,
  output logic [SLOT_W-1:0] rdData,
  output logic [6:0]        slotFlags
);

  slotStrb_t  strb;
  slotFlags_t flags;

  codec_slot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (slotSel_e'(wrSel)),
    .rdFlagIn (wrData[SLOT_W-1]),
    .rdEn     (rdEn),
    .rdSel    (slotSel_e'(rdSel)),
    .strb     (strb),
    .flags    (flags)
  );

  codec_slot_dp #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdSel  (slotSel_e'(rdSel)),
    .rdData (rdData)
  );

  assign slotFlags = flags;

endmodule

// File: tb/codec_cmd_slot_bench.sv
module codec_cmd_slot_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [6:0]  wa;
    logic [15:0] wd;
    logic [6:0]  ra;
    logic [15:0] ex;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h02, 16'h1234, 7'h02, 16'h1234},
    '{7'h03, 16'hABCD, 7'h02, 16'hABCD},
    '{7'h10, 16'hFFFF, 7'h11, 16'hFFFF},
    '{7'h7E, 16'h0001, 7'h7F, 16'h0001},
    '{7'h20, 16'h8000, 7'h22, 16'h0000},
    '{7'h22, 16'h5A5A, 7'h10, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [19:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdSel = 2'd0;
  logic [19:0] rdData;
  logic [6:0]  slotFlags;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_cmd_slot u_codec_cmd_slot (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .slotFlags(slotFlags)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [19:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [19:0] val);
    rdSel = sel;
    #1 val = rdData;
  endtask

  task automatic consume(input logic [1:0] sel, output logic [19:0] val);
    @(negedge clk);
    rdEn = 1'b1; rdSel = sel;
    #1 val = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [19:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", slotFlags, 7'h07);
    peek(2'd2, v); check("R1 rxCmd", v, 20'h0);
    peek(2'd3, v); check("R1 rxDat", v, 20'h0);

    // R2 data slot only
    hostWrite(2'd1, 20'h00000);
    check("R2 data write flags", slotFlags, 7'h01);

    // R5 read of an unwritten entry
    hostWrite(2'd0, {1'b1, 7'h40, 12'hABC});
    check("R5 busy after load", slotFlags, 7'h18);
    @(negedge clk);
    check("R5 valid after done", slotFlags, 7'h60);
    // R4 echo, R6 consume
    consume(2'd2, v);
    check("R4 rxCmd echo", v, {1'b0, 7'h40, 12'hABC});
    check("R6 rx1 valid cleared", slotFlags, 7'h20 << 1);
    consume(2'd0, v);
    check("R6 tx read no flag change", slotFlags, 7'h40);
    consume(2'd3, v);
    check("R8 reset bank entry", v, 20'h0);
    check("R6 rx2 valid cleared", slotFlags, 7'h00);

    // R3/R4 vector table
    for (int i = 0; i < 6; i++) begin
      hostWrite(2'd1, {VECS[i].wd, 4'h0});
      hostWrite(2'd0, {1'b0, VECS[i].wa, 12'h000});
      @(negedge clk);
      check("R7 write keeps valid", slotFlags, 7'h00);
      hostWrite(2'd0, {1'b1, VECS[i].ra, 12'h5A5});
      @(negedge clk);
      consume(2'd3, v);
      check("R3 readback", v, {VECS[i].ex, 4'h0});
      consume(2'd2, v);
      check("R4 echo bit19 clear", v, {1'b0, VECS[i].ra, 12'h5A5});
    end

    // R7 write command with valid data pending
    hostWrite(2'd0, {1'b1, 7'h02, 12'h111});
    @(negedge clk);
    hostWrite(2'd1, {16'h7777, 4'hF});
    hostWrite(2'd0, {1'b0, 7'h02, 12'h000});
    @(negedge clk);
    check("R7 flags after write cmd", slotFlags, 7'h60);
    peek(2'd3, v); check("R7 rxDat held", v, {16'hABCD, 4'h0});
    peek(2'd2, v); check("R7 rxCmd held", v, {1'b0, 7'h02, 12'h111});
    consume(2'd2, v);
    consume(2'd3, v);

    // R9 completion coincides with consume
    hostWrite(2'd0, {1'b1, 7'h02, 12'h222});
    rdEn = 1'b1; rdSel = 2'd2;
    @(negedge clk);
    rdEn = 1'b0;
    check("R9 valid survives consume", slotFlags[5], 1'b1);
    peek(2'd3, v); check("R3 aliased write landed", v, {16'h7777, 4'h0});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule